// File: doc/BRIEF.md
# Core Register File with Live Source-Path Special Registers

This block is the local register store of one processor core: 512 words of 32 bits, read through three ports at once and written through one. The fetch port supplies instruction words, the destination port supplies the destination operand and the source port supplies the source operand. Write-back from the execution stage goes through the single write port. All three reads are synchronous: an address presented before a rising edge yields its word just after that edge.

The sixteen highest addresses form a window for special registers. Four of them carry live hardware values: a launch parameter, a free-running cycle counter and two sampled input-pin ports. The live value replaces the stored word only on the source port. On the fetch and destination ports every address, special or not, returns the word held in RAM. That stored word is a shadow cell, so a program may write a jump into a special address and later execute it from there. Decoding and arithmetic sit outside this block.

Top module: `rfs_regfile`

## Requirements
- R1: A plain address requested on any read port appears on that port's data output one clock edge later, holding the last word written there.
- R2: When a write and a read hit the same address at the same edge, the read returns the word held before that write, and the new word is returned from the next edge on.
- R3: A fetch read at a special address (0x1F0 to 0x1FF) returns the word last written there through the write port, never a live value.
- R4: A destination read at a special address returns the stored word, never a live value.
- R5: A source read at 0x1F0 returns the value on `param_in` at the reading edge.
- R6: A source read at 0x1F1 returns a 32-bit counter that holds 0 at the first edge after reset and then rises by one at every edge, wrapping at its maximum.
- R7: A source read at 0x1F2 returns `pin_a`, and at 0x1F3 returns `pin_b`, each delayed by a two-flop synchroniser (the value from two edges before the reading edge).
- R8: While `rst_n` is low at an edge, all three read outputs become 0 after that edge, and the counter and the synchronisers clear.
- R9: A source read at a special address other than 0x1F0 to 0x1F3 returns the stored word like plain RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_addr | input | 9 | Instruction fetch address |
| fetch_data | output | 32 | Fetched word, one edge after the address |
| dst_addr | input | 9 | Destination operand address |
| dst_data | output | 32 | Destination operand word |
| src_addr | input | 9 | Source operand address |
| src_data | output | 32 | Source operand word or live special value |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 9 | Write address |
| wr_data | input | 32 | Write word |
| param_in | input | 32 | Live launch parameter |
| pin_a | input | 32 | Input pin port A, asynchronous |
| pin_b | input | 32 | Input pin port B, asynchronous |

## Verification
A corrupted storage cell or a wrong read-before-write order shows on the very next read of that address on any port, one edge after the request, because every output is compared against the model each cycle. A live-select decode that leaks onto the fetch or destination path shows as soon as a special address is read there, since the stored shadow word and the live value differ. A counter that skips or stalls shows on the second of two back-to-back counter reads, and a synchroniser with the wrong depth shows within three edges of the first pin change.

// File: rtl/rfs_pkg.sv
// Shared definitions for the shadowed register file.
// Assumes the special window is the top 16 words of the address space.
package rfs_pkg;

    // Which value the source port delivers after the edge
    typedef enum logic [2:0] {
        SRC_RAM  = 3'd0,
        SRC_PAR  = 3'd1,
        SRC_CNT  = 3'd2,
        SRC_PINA = 3'd3,
        SRC_PINB = 3'd4
    } src_pick_e;

    // Offsets inside the 16-word special window
    localparam logic [3:0] OFS_PAR  = 4'h0;
    localparam logic [3:0] OFS_CNT  = 4'h1;
    localparam logic [3:0] OFS_PINA = 4'h2;
    localparam logic [3:0] OFS_PINB = 4'h3;

    // Map an address (window flag plus low nibble) to the source pick
    function automatic src_pick_e pick_for(input logic in_window, input logic [3:0] low);
        src_pick_e p;
        p = SRC_RAM;
        if (in_window) begin
            case (low)
                OFS_PAR:  p = SRC_PAR;
                OFS_CNT:  p = SRC_CNT;
                OFS_PINA: p = SRC_PINA;
                OFS_PINB: p = SRC_PINB;
                default:  p = SRC_RAM;
            endcase
        end
        return p;
    endfunction

endpackage

// File: rtl/rfs_store.sv
// Word storage with NRD synchronous read ports and one write port.
// Reads capture the word held before a same-edge write (read-before-write).
// Assumes the array itself needs no reset; only the read registers clear.
module rfs_store #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 32,
    parameter int NRD    = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NRD-1:0][ADDR_W-1:0]     rd_addr,
    output logic [NRD-1:0][DATA_W-1:0]     rd_data,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [DATA_W-1:0]              wr_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Store the write-back word
    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_addr] <= wr_data;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        // Capture the addressed word for read port p
        always_ff @(posedge clk) begin
            if (!rst_n) rd_data[p] <= '0;
            else        rd_data[p] <= cells[rd_addr[p]];
        end
    end

endmodule

// File: rtl/rfs_tick.sv
// Free-running up-counter, cleared by reset, wraps at its maximum.
module rfs_tick #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] STEP = 1;

    // Advance by one on every edge
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + STEP;
    end

endmodule

// File: rtl/rfs_insync.sv
// Multi-flop synchroniser for an asynchronous input port.
// Assumes STAGES >= 1; output lags the input by STAGES edges.
module rfs_insync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain;

    // First stage samples the raw pins
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Later stages pass the value along
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/rfs_regfile.sv
// Core register file: three synchronous read ports (fetch, destination,
// source) and one write port. Special words in the top 16 addresses give
// live values only on the source port; elsewhere the stored shadow word
// is returned. Assumes ADDR_W >= 5.
module rfs_regfile #(
    parameter int ADDR_W     = 9,
    parameter int DATA_W     = 32,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [DATA_W-1:0] fetch_data,
    input  logic [ADDR_W-1:0] dst_addr,
    output logic [DATA_W-1:0] dst_data,
    input  logic [ADDR_W-1:0] src_addr,
    output logic [DATA_W-1:0] src_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] param_in,
    input  logic [DATA_W-1:0] pin_a,
    input  logic [DATA_W-1:0] pin_b
);
    import rfs_pkg::*;

    localparam int NRD   = 3;
    localparam int P_FET = 0;
    localparam int P_DST = 1;
    localparam int P_SRC = 2;
    localparam int HI_W  = ADDR_W - 4;

    logic [NRD-1:0][ADDR_W-1:0] rd_addr;
    logic [NRD-1:0][DATA_W-1:0] rd_data;
    logic [DATA_W-1:0]          cycle_cnt;
    logic [DATA_W-1:0]          pa_sync;
    logic [DATA_W-1:0]          pb_sync;
    logic                       src_in_window;
    src_pick_e                  pick_d;
    src_pick_e                  pick_q;
    logic [DATA_W-1:0]          live_d;
    logic [DATA_W-1:0]          live_q;

    assign rd_addr[P_FET] = fetch_addr;
    assign rd_addr[P_DST] = dst_addr;
    assign rd_addr[P_SRC] = src_addr;

    rfs_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NRD(NRD)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    rfs_tick #(.W(DATA_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .count (cycle_cnt)
    );

    rfs_insync #(.W(DATA_W), .STAGES(SYNC_DEPTH)) u_sync_a (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_a),
        .dout  (pa_sync)
    );

    rfs_insync #(.W(DATA_W), .STAGES(SYNC_DEPTH)) u_sync_b (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_b),
        .dout  (pb_sync)
    );

    // Decode the source address and choose the live candidate
    always_comb begin
        src_in_window = &src_addr[ADDR_W-1:4];
        pick_d        = pick_for(src_in_window, src_addr[3:0]);
        case (pick_d)
            SRC_PAR:  live_d = param_in;
            SRC_CNT:  live_d = cycle_cnt;
            SRC_PINA: live_d = pa_sync;
            SRC_PINB: live_d = pb_sync;
            default:  live_d = '0;
        endcase
    end

    // Register the pick and the live value alongside the RAM read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pick_q <= SRC_RAM;
            live_q <= '0;
        end else begin
            pick_q <= pick_d;
            live_q <= live_d;
        end
    end

    // Deliver the outputs; only the source port can see live values
    assign fetch_data = rd_data[P_FET];
    assign dst_data   = rd_data[P_DST];
    assign src_data   = (pick_q == SRC_RAM) ? rd_data[P_SRC] : live_q;

    logic unused_hi;
    assign unused_hi = ^{HI_W{1'b0}};

endmodule

// File: rtl/rfs_regfile_chk.sv
// Port-level properties of the shadowed register file, bound to the top.
module rfs_regfile_chk #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic [DATA_W-1:0] fetch_data,
    input logic [ADDR_W-1:0] dst_addr,
    input logic [DATA_W-1:0] dst_data,
    input logic [ADDR_W-1:0] src_addr,
    input logic [DATA_W-1:0] src_data,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] param_in,
    input logic [DATA_W-1:0] pin_a,
    input logic [DATA_W-1:0] pin_b
);
    localparam logic [ADDR_W-1:0] A_PAR  = {{(ADDR_W-4){1'b1}}, 4'h0};
    localparam logic [ADDR_W-1:0] A_CNT  = {{(ADDR_W-4){1'b1}}, 4'h1};
    localparam logic [ADDR_W-1:0] A_PINA = {{(ADDR_W-4){1'b1}}, 4'h2};
    localparam logic [ADDR_W-1:0] A_PINB = {{(ADDR_W-4){1'b1}}, 4'h3};
    localparam logic [DATA_W-1:0] ONE    = 1;

    function automatic logic is_live(input logic [ADDR_W-1:0] a);
        return (a == A_PAR) || (a == A_CNT) || (a == A_PINA) || (a == A_PINB);
    endfunction

    // R1 / R3: a written word is fetched back when no later write intervenes
    a_r3_fetch_sees_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en, 2) && ($past(fetch_addr) == $past(wr_addr, 2))
         && !($past(wr_en) && ($past(wr_addr) == $past(wr_addr, 2))))
        |-> (fetch_data == $past(wr_data, 2)));

    // R4: destination port equals fetch port for the same address, live or not
    a_r4_dst_is_shadow: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(dst_addr) == $past(fetch_addr)))
        |-> (dst_data == fetch_data));

    // R9 / R1: source port equals fetch port for non-live addresses
    a_r9_src_plain: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(src_addr) == $past(fetch_addr)) && !is_live($past(src_addr)))
        |-> (src_data == fetch_data));

    // R5: parameter read returns the value at the reading edge
    a_r5_param_live: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(src_addr) == A_PAR))
        |-> (src_data == $past(param_in)));

    // R6: back-to-back counter reads differ by exactly one
    a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && ($past(src_addr) == A_CNT) && ($past(src_addr, 2) == A_CNT))
        |-> (src_data == $past(src_data) + ONE));

    // R7: port A arrives through two flops
    a_r7_pin_a_delay: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3) && ($past(src_addr) == A_PINA))
        |-> (src_data == $past(pin_a, 3)));

    // R7: port B arrives through two flops
    a_r7_pin_b_delay: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3) && ($past(src_addr) == A_PINB))
        |-> (src_data == $past(pin_b, 3)));

    // R8: an edge under reset leaves all outputs at zero
    a_r8_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> ((fetch_data == '0) && (dst_data == '0) && (src_data == '0)));

endmodule

bind rfs_regfile rfs_regfile_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_addr (fetch_addr),
    .fetch_data (fetch_data),
    .dst_addr   (dst_addr),
    .dst_data   (dst_data),
    .src_addr   (src_addr),
    .src_data   (src_data),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .param_in   (param_in),
    .pin_a      (pin_a),
    .pin_b      (pin_b)
);

// File: tb/sim_rfs_regfile.sv
// Bench for rfs_regfile: a behavioural model predicts all three outputs
// every cycle; outputs are sampled on the falling edge.
module sim_rfs_regfile;
    localparam int AW = 9;
    localparam int DW = 32;
    localparam int N  = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] fetch_addr = '0, dst_addr = '0, src_addr = '0, wr_addr = '0;
    logic [DW-1:0] fetch_data, dst_data, src_data;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0, param_in = '0, pin_a = '0, pin_b = '0;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done  = 0;

    // model state
    logic [DW-1:0] mm [N];
    bit            mk [N];
    logic [DW-1:0] m_cnt = '0;
    logic [DW-1:0] m_a1 = '0, m_a2 = '0, m_b1 = '0, m_b2 = '0;

    always #10 clk = ~clk;

    rfs_regfile u0 (
        .clk(clk), .rst_n(rst_n),
        .fetch_addr(fetch_addr), .fetch_data(fetch_data),
        .dst_addr(dst_addr), .dst_data(dst_data),
        .src_addr(src_addr), .src_data(src_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .param_in(param_in), .pin_a(pin_a), .pin_b(pin_b)
    );

    task automatic check(string tag, string port, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h at cycle %0d", tag, port, act, exp, cycles);
        end
    endtask

    // one clock: predict from current inputs, advance model, compare after edge
    task automatic tick();
        logic [DW-1:0] ef, ed, es;
        bit kf, kd, ks;
        string tf, td, ts;
        int fa, da, sa;
        fa = int'(fetch_addr); da = int'(dst_addr); sa = int'(src_addr);
        tf = (fa >= 'h1F0) ? "R3" : "R1";
        td = (da >= 'h1F0) ? "R4" : "R1";
        ts = (sa >= 'h1F0) ? "R9" : "R1";
        ef = mm[fa]; kf = mk[fa];
        ed = mm[da]; kd = mk[da];
        es = mm[sa]; ks = mk[sa];
        case (sa)
            'h1F0: begin es = param_in; ks = 1; ts = "R5"; end
            'h1F1: begin es = m_cnt;    ks = 1; ts = "R6"; end
            'h1F2: begin es = m_a2;     ks = 1; ts = "R7"; end
            'h1F3: begin es = m_b2;     ks = 1; ts = "R7"; end
            default: ;
        endcase
        if (wr_en && int'(wr_addr) == fa) tf = "R2";
        if (wr_en && int'(wr_addr) == da) td = "R2";
        if (wr_en && int'(wr_addr) == sa && ts != "R5" && ts != "R6" && ts != "R7") ts = "R2";
        if (!rst_n) begin
            ef = '0; ed = '0; es = '0; kf = 1; kd = 1; ks = 1;
            tf = "R8"; td = "R8"; ts = "R8";
            m_cnt = '0; m_a1 = '0; m_a2 = '0; m_b1 = '0; m_b2 = '0;
        end else begin
            m_cnt = m_cnt + 1;
            m_a2 = m_a1; m_a1 = pin_a;
            m_b2 = m_b1; m_b1 = pin_b;
        end
        if (wr_en) begin mm[int'(wr_addr)] = wr_data; mk[int'(wr_addr)] = 1; end
        @(posedge clk);
        @(negedge clk);
        cycles++;
        if (kf) check(tf, "fetch", fetch_data, ef);
        if (kd) check(td, "dst", dst_data, ed);
        if (ks) check(ts, "src", src_data, es);
    endtask

    task automatic drive(bit we, int wa, logic [DW-1:0] wd, int fa, int da, int sa);
        wr_en = we; wr_addr = AW'(wa); wr_data = wd;
        fetch_addr = AW'(fa); dst_addr = AW'(da); src_addr = AW'(sa);
        tick();
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] c0, c1;
        for (int i = 0; i < N; i++) mk[i] = 0;
        @(negedge clk);
        // R8: reset state
        repeat (3) drive(0, 0, '0, 'h1F1, 'h1F2, 'h1F1);
        rst_n = 1'b1;
        // fill every word (also covers R3 shadow writes of the special window)
        for (int i = 0; i < N; i++)
            drive(1, i, DW'(i) * 32'h9E37_79B1 ^ 32'h5A5A_0000, (i + N - 1) % N, i, (i + 7) % N);
        // R1: plain reads under varied patterns
        for (int i = 0; i < 300; i++)
            drive(0, 0, '0, $urandom % 'h1F0, $urandom % N, $urandom % N);
        // R2: same-edge write and read
        drive(1, 'h010, 32'hCAFE_0001, 'h010, 'h010, 'h010);
        drive(0, 0, '0, 'h010, 'h010, 'h010);
        // R3/R4/R5: jump word placed at 0x1F0, live parameter on the source port
        param_in = 32'h1234_5678;
        drive(1, 'h1F0, 32'h5C7C_01E8, 'h1F1, 'h1F2, 'h1F3);
        drive(0, 0, '0, 'h1F0, 'h1F0, 'h1F0);
        param_in = 32'h8765_4321;
        drive(0, 0, '0, 'h1F0, 'h1F1, 'h1F0);
        // R6: back-to-back counter reads, explicit increment check
        drive(0, 0, '0, 'h1F1, 'h1F1, 'h1F1);
        c0 = src_data;
        drive(0, 0, '0, 'h1F1, 'h1F1, 'h1F1);
        c1 = src_data;
        check("R6", "cnt_step", c1, c0 + 1);
        // R7: pin changes seen after two flops
        for (int i = 0; i < 20; i++) begin
            pin_a = $urandom; pin_b = $urandom;
            drive(0, 0, '0, 'h1F2, 'h1F3, (i % 2) ? 'h1F3 : 'h1F2);
        end
        // R9: remaining window words behave as RAM on the source port
        for (int i = 4; i < 16; i++) begin
            drive(1, 'h1F0 + i, 32'hB000_0000 + DW'(i), 'h1F0 + i, 'h1F0 + i, 'h1F0 + i);
            drive(0, 0, '0, 'h1F0 + i, 'h1F0 + i, 'h1F0 + i);
        end
        // mixed traffic with writes
        for (int i = 0; i < 400; i++)
            drive($urandom % 2, $urandom % N, $urandom, $urandom % N, $urandom % N, $urandom % N);
        // R8: mid-run reset, counter restarts from 0
        rst_n = 1'b0;
        drive(1, 'h020, 32'h0BAD_F00D, 'h020, 'h1F1, 'h1F1);
        rst_n = 1'b1;
        drive(0, 0, '0, 'h020, 'h1F1, 'h1F1);
        check("R6", "cnt_after_reset", src_data, 32'd0);
        drive(0, 0, '0, 'h020, 'h1F1, 'h1F1);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule